// File: doc/BRIEF.md
# Scan-Based Logic Self-Test Sequencer

This block runs a complete logic self-test over a small built-in combinational circuit wrapped in parallel scan chains. A 16-bit pseudo-random generator feeds an XOR spreading network that drives one serial input per chain. The serial outputs of all chains are folded by XOR onto a narrower word, and that word is absorbed by a multiple-input signature register. A shift counter and a pattern counter open and close the shift and capture windows. Each pattern is loaded serially over a window as long as a chain. One capture cycle then loads the circuit response into the scan cells, and the following shift window unloads that response while loading the next pattern.

A single `start` pulse, standing in for a test-access instruction, seeds the generator and the signature register and starts the run. After the last pattern one extra unload window pushes the final response into the signature. The block then raises `done` and holds it until the next start. `pass` reports whether the final signature equals the reference word supplied on `ref_sig`. A parameter can inject a stuck-at fault on one captured cell, so the same block also serves as a faulty copy for checking that the test detects defects.

Top module: `scan_selftest`

## Requirements
- R1: While reset is asserted and after it is released, `busy`, `done` and `pass` are low.
- R2: A `start` seen high at a clock edge while `busy` is low begins a run. From the next cycle `busy` is high and `done` is low.
- R3: A run consists of NPAT+1 shift windows of DEPTH cycles each, with one capture cycle after each of the first NPAT windows and none after the last. `busy` is therefore high for exactly (NPAT+1)*DEPTH+NPAT cycles (1104 with the default parameters).
- R4: The generator is seeded to LFSR_SEED at start and shifts toward its top bit. Its new bit 0 is the XOR of bits 15, 13, 12 and 10. It advances only in shift cycles. During a shift cycle, chain c receives generator bit (c mod 16) XOR generator bit ((3c+7) mod 16), using the value before the step.
- R5: Each chain shifts toward its top cell, the serial input entering cell 0 and cell DEPTH-1 being the serial output. Chains are cleared at start. In a capture cycle every cell (c,d) loads x[c][d] XOR (x[(c+1) mod 8][d] AND NOT x[(c+3) mod 8][(d+1) mod 16]), where x is the chain contents.
- R6: The output of chain c is XORed onto compactor line (c mod 4). The signature register is seeded to MISR_SEED at start. In each shift cycle it becomes {sig[14:0], XOR of sig bits 15,13,12,10} XOR the 4-bit compactor word placed in bits 3:0. It holds in capture cycles.
- R7: At the end of the run `busy` falls and `done` rises in the same cycle. `done` stays high until the next start.
- R8: `pass` is high exactly when `done` is high and the signature equals `ref_sig`. It follows `ref_sig` combinationally, so any single flipped reference bit clears it.
- R9: `start` while `busy` is high is ignored. The run length and the final signature are unchanged.
- R10: With a stuck-at fault injected on one captured cell, a fault-free reference signature yields `pass` low at `done`.
- R11: Starting again after `done` repeats the run from the same seeds and gives the same signature.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begins a run when the block is idle |
| ref_sig | input | 16 | Expected final signature |
| busy | output | 1 | Run in progress |
| done | output | 1 | Run finished, held until next start |
| pass | output | 1 | Done and signature matches `ref_sig` |

## Verification
The assertions take for granted that reset is held low from time zero until after the first clock edge. They also assume that `start` and `ref_sig` change only between clock edges. The done-hold property also assumes that any start pulse after a finished run is meant to restart it. The bench drives every input on the falling edge, holds reset over several edges, and keeps `ref_sig` fixed during a run. It changes `ref_sig` only while `done` is high, to sweep single-bit mismatches. Mid-run start pulses are applied on purpose to exercise the ignore rule. They fall inside the windows where the properties allow them.

// File: rtl/scan_selftest.sv
module scan_selftest #(
  parameter int NCH = 8,
  parameter int DEPTH = 16,
  parameter int LW = 16,
  parameter logic [LW-1:0] TAPS = 16'hB400,
  parameter int CW = 4,
  parameter int NPAT = 64,
  parameter logic [LW-1:0] LFSR_SEED = 16'hACE1,
  parameter logic [LW-1:0] MISR_SEED = 16'h1D0F,
  parameter bit FAULT_EN = 1'b0,
  parameter int FAULT_CH = 0,
  parameter int FAULT_POS = 0,
  parameter bit FAULT_VAL = 1'b0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [LW-1:0] ref_sig,
  output logic          busy,
  output logic          done,
  output logic          pass
);
  localparam int SCW = $clog2(DEPTH);
  localparam int PCW = $clog2(NPAT + 1);

  typedef enum logic [1:0] {S_IDLE, S_SHIFT, S_CAP} st_t;

  st_t st;
  logic [LW-1:0] lfsr, misr, misr_nx;
  logic [NCH-1:0][DEPTH-1:0] chain, resp;
  logic [NCH-1:0] si, so;
  logic [CW-1:0] comp;
  logic [SCW-1:0] shcnt;
  logic [PCW-1:0] patcnt;

  wire lfb = ^(lfsr & TAPS);
  wire mfb = ^(misr & TAPS);

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    assign si[c] = lfsr[c % LW] ^ lfsr[(3 * c + 7) % LW];
    assign so[c] = chain[c][DEPTH-1];
    for (genvar d = 0; d < DEPTH; d++) begin : g_cell
      if (FAULT_EN && c == FAULT_CH && d == FAULT_POS) begin : g_stuck
        assign resp[c][d] = FAULT_VAL;
      end else begin : g_ok
        assign resp[c][d] = chain[c][d] ^
          (chain[(c + 1) % NCH][d] & ~chain[(c + 3) % NCH][(d + 1) % DEPTH]);
      end
    end
  end

  always_comb begin
    comp = '0;
    for (int c = 0; c < NCH; c++) comp[c % CW] = comp[c % CW] ^ so[c];
  end

  assign misr_nx = {misr[LW-2:0], mfb} ^ {{(LW-CW){1'b0}}, comp};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      done   <= 1'b0;
      lfsr   <= LFSR_SEED;
      misr   <= MISR_SEED;
      chain  <= '0;
      shcnt  <= '0;
      patcnt <= '0;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          st     <= S_SHIFT;
          done   <= 1'b0;
          lfsr   <= LFSR_SEED;
          misr   <= MISR_SEED;
          chain  <= '0;
          shcnt  <= SCW'(DEPTH - 1);
          patcnt <= PCW'(NPAT);
        end
        S_SHIFT: begin
          lfsr <= {lfsr[LW-2:0], lfb};
          misr <= misr_nx;
          for (int c = 0; c < NCH; c++) chain[c] <= {chain[c][DEPTH-2:0], si[c]};
          if (shcnt == '0) begin
            if (patcnt == '0) begin
              st   <= S_IDLE;
              done <= 1'b1;
            end else begin
              st <= S_CAP;
            end
          end else begin
            shcnt <= shcnt - 1'b1;
          end
        end
        S_CAP: begin
          chain  <= resp;
          patcnt <= patcnt - 1'b1;
          shcnt  <= SCW'(DEPTH - 1);
          st     <= S_SHIFT;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign busy = (st != S_IDLE);
  assign pass = done && (misr == ref_sig);
endmodule

module scan_selftest_chk #(
  parameter int LW = 16,
  parameter int PCW = 7
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic          busy,
  input logic          done,
  input logic          pass,
  input logic [1:0]    st,
  input logic [LW-1:0] lfsr,
  input logic [LW-1:0] misr,
  input logic [PCW-1:0] patcnt
);
  // R7
  busy_done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n) !(busy && done));
  // R8
  pass_needs_done_chk: assert property (@(posedge clk) disable iff (!rst_n) pass |-> done);
  // R7
  done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n) (done && !start) |=> done);
  // R2
  start_launch_chk: assert property (@(posedge clk) disable iff (!rst_n) (!busy && start) |=> (busy && !done));
  // R7
  done_rise_chk: assert property (@(posedge clk) disable iff (!rst_n) $rose(done) |-> $fell(busy));
  // R4
  lfsr_cap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n) (st == 2'd2) |=> $stable(lfsr));
  // R6
  misr_cap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n) (st == 2'd2) |=> $stable(misr));
  // R3
  cap_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n) (st == 2'd2) |=> (st == 2'd1));
  // R3
  pat_step_chk: assert property (@(posedge clk) disable iff (!rst_n) (st == 2'd2) |=> (patcnt == $past(patcnt) - 1'b1));
endmodule

bind scan_selftest scan_selftest_chk #(.LW(LW), .PCW(PCW)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done), .pass(pass),
  .st(st), .lfsr(lfsr), .misr(misr), .patcnt(patcnt)
);

// File: tb/scan_selftest_tb.sv
`timescale 1ns/1ps
module scan_selftest_tb;
  localparam int NPAT = 64;
  localparam logic [15:0] LSEED = 16'hACE1;
  localparam logic [15:0] MSEED = 16'h1D0F;
  localparam logic [15:0] TAPS = 16'hB400;
  localparam int RUNLEN = (NPAT + 1) * 16 + NPAT;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [15:0] ref_sig = '0;
  logic busy, done, pass, b_busy, b_done, b_pass;
  int checks = 0;
  int failures = 0;
  logic [15:0] golden;

  always #4 clk = ~clk;

  scan_selftest #(.NPAT(NPAT), .LFSR_SEED(LSEED), .MISR_SEED(MSEED)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .ref_sig(ref_sig),
    .busy(busy), .done(done), .pass(pass));

  scan_selftest #(.NPAT(NPAT), .LFSR_SEED(LSEED), .MISR_SEED(MSEED),
    .FAULT_EN(1'b1), .FAULT_CH(2), .FAULT_POS(5), .FAULT_VAL(1'b1)) u_bad (
    .clk(clk), .rst_n(rst_n), .start(start), .ref_sig(ref_sig),
    .busy(b_busy), .done(b_done), .pass(b_pass));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [15:0] model();
    logic [15:0] l, m, mn;
    logic [15:0] ch [8];
    logic [15:0] r [8];
    logic [7:0] nb;
    logic [3:0] cp;
    l = LSEED;
    m = MSEED;
    for (int c = 0; c < 8; c++) ch[c] = '0;
    for (int w = 0; w <= NPAT; w++) begin
      for (int s = 0; s < 16; s++) begin
        cp = '0;
        for (int c = 0; c < 8; c++) cp[c % 4] = cp[c % 4] ^ ch[c][15];
        mn = {m[14:0], ^(m & TAPS)} ^ {12'b0, cp};
        for (int c = 0; c < 8; c++) nb[c] = l[c % 16] ^ l[(3 * c + 7) % 16];
        l = {l[14:0], ^(l & TAPS)};
        for (int c = 0; c < 8; c++) ch[c] = {ch[c][14:0], nb[c]};
        m = mn;
      end
      if (w < NPAT) begin
        for (int c = 0; c < 8; c++)
          for (int d = 0; d < 16; d++)
            r[c][d] = ch[c][d] ^ (ch[(c + 1) % 8][d] & ~ch[(c + 3) % 8][(d + 1) % 16]);
        for (int c = 0; c < 8; c++) ch[c] = r[c];
      end
    end
    return m;
  endfunction

  task automatic run(input bit mid);
    int cnt;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    chk(busy && !done, "R2 busy after start", {busy, done}, 2);
    cnt = 0;
    while (busy && cnt < 5000) begin
      cnt++;
      if (cnt == 100) chk(!pass, "R8 pass low while busy", pass, 0);
      start = (mid && (cnt == 300 || cnt == 700));
      @(negedge clk);
    end
    start = 1'b0;
    chk(cnt == RUNLEN, mid ? "R9 run length with start while busy" : "R3 run length", cnt, RUNLEN);
    chk(done, "R7 done at end", done, 1);
    chk(pass, mid ? "R11/R9 pass on rerun" : "R4 R5 R6 signature matches model", pass, 1);
    chk(b_done && !b_pass, "R10 stuck-at fault clears pass", {b_done, b_pass}, 2);
  endtask

  initial begin
    #(8 * 200000);
    chk(1'b0, "watchdog expired", 0, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    golden = model();
    ref_sig = golden;
    repeat (3) @(negedge clk);
    chk(!busy && !done && !pass, "R1 reset outputs", {busy, done, pass}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !done && !pass, "R1 idle after reset", {busy, done, pass}, 0);
    run(1'b0);
    repeat (10) @(negedge clk);
    chk(done && pass, "R7 done held", {done, pass}, 3);
    for (int b = 0; b < 16; b++) begin
      ref_sig = golden ^ (16'h1 << b);
      #1;
      chk(!pass, "R8 flipped reference bit", pass, 0);
    end
    ref_sig = golden;
    #1;
    chk(pass, "R8 reference restored", pass, 1);
    run(1'b1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule